// File: doc/BRIEF.md
# Per-Bit Read Capture Delay Trainer

This block trains the read-capture delay of every data bit in one byte lane of a source-synchronous DDR2-style read path. It does not apply one phase offset to the whole bus. It steps each bit's delay element through its full tap range, one bit at a time, and samples that bit against the strobe at the controller clock. It finds the taps where the sampled value changes, which are the edges of the data eye, and parks the bit's delay in the middle of the eye. Because every bit is centred on its own delay, strobe-to-data skew, hold skew and strobe distortion no longer eat into the window. The usable window then approaches the full data period, which is about 1.7 ns at the target rate. That is far wider than the few tens of picoseconds left to a single fixed phase shift, so the delay taps have to be fine.

Software or a sequencer starts a full training pass with `cal_start`. The block raises `cal_done` for one cycle once every bit has its new tap. After each pass a timer runs. When it expires, `recal_req` rises and the block waits for the read path to be idle before it runs a tracking pass. A tracking pass may move each tap by at most one step, so that drift from voltage and temperature is followed without jumps. The delay line and the pads are outside this block. The block only drives each delay element's tap value and a load strobe.

Top module: `dq_capture_trainer`

## Requirements
- R1: After reset, all taps are 0, no load strobe or error flag is set, and `cal_done` and `recal_req` are low.
- R2: The value seen at a tap is the majority of VOTES (8) consecutive reads of `dq_smp[b] ^ dqs_smp`. With 8 reads, the value is 1 when at least 5 reads are 1.
- R3: After each load of a sweep tap, the block waits SETTLE cycles before the first of its reads.
- R4: A pass trains bits 0 to NBITS-1 in order. Each bit's tap is swept from 0 to 63 and then its final tap is loaded, which makes 65 loads per bit. At most one `tap_load` bit is high at a time, and bit b's tap sits in `tap_val[b*6 +: 6]`.
- R5: An edge is a tap t ≥ 1 whose value differs from the value at tap t-1. With two or more edges, the new tap is floor((first edge + second edge)/2).
- R6: With exactly one edge e, the new tap is e − HALF_EYE if e ≥ HALF_EYE. Otherwise it is e + HALF_EYE, clamped to 63.
- R7: With no edge, the bit keeps its previous tap and its `cal_err` bit is set. A bit that finds an edge has its `cal_err` bit cleared.
- R8: `cal_done` is high for exactly one cycle, after the final tap of the last bit is loaded.
- R9: `recal_req` rises RECAL_INTERVAL cycles after a `cal_done` pulse. A tracking pass starts only in a cycle where `rd_idle` is high, with no tap load before that. Starting the pass clears `recal_req`.
- R10: In a tracking pass, each bit's final tap moves at most one step from its previous value, toward the tap a full pass would pick. A full pass moves taps freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Starts a full training pass when the block is idle |
| rd_idle | input | 1 | High when the read path may be disturbed by a tracking pass |
| dqs_smp | input | 1 | Strobe value sampled at the controller clock |
| dq_smp | input | NBITS | Data bits sampled at the controller clock |
| cal_done | output | 1 | One-cycle pulse at the end of a pass |
| recal_req | output | 1 | A tracking pass is due and waits for `rd_idle` |
| tap_val | output | NBITS*TAP_W | Tap value for each bit's delay element |
| tap_load | output | NBITS | Per-bit load strobe for the delay element |
| cal_err | output | NBITS | Per-bit flag: no eye edge found in the last pass |

## Verification
The hardest situation to reach from the ports is a tracking pass whose targets sit several taps away from the current settings, so that the one-step limit actually bites. The bench reaches it in three steps. It first trains the lane fully, so the taps are known. It then holds `rd_idle` low past the timer expiry, to show the request waits. Finally it moves the behavioural eye windows by different amounts per bit before releasing idle. The delay model also returns inverted data for the settle cycles after each load and flips about one read in seven on a strobe-inverted pass, so early sampling or a broken majority vote shows up as wrong taps.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETTLE, S_VOTE, S_DECIDE, S_APPLY, S_DONE
  } cal_state_e;
endpackage

// File: rtl/cal_vote_acc.sv
module cal_vote_acc #(
  parameter int VOTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic maj
);
  localparam int CW = $clog2(VOTES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (en & din) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign maj = (cnt_q > CW'(VOTES / 2));
endmodule

// File: rtl/cal_edge_find.sv
module cal_edge_find #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             first,
  input  logic             val,
  input  logic [TAP_W-1:0] tap,
  output logic [1:0]       n_edges,
  output logic [TAP_W-1:0] e1,
  output logic [TAP_W-1:0] e2
);
  logic             prev_q, prev_d;
  logic [1:0]       n_q, n_d;
  logic [TAP_W-1:0] e1_q, e1_d, e2_q, e2_d;

  always_comb begin
    prev_d = prev_q; n_d = n_q; e1_d = e1_q; e2_d = e2_q;
    if (clr) begin
      n_d = '0;
    end else if (en) begin
      prev_d = val;
      if (!first && (val != prev_q) && (n_q != 2'd2)) begin
        if (n_q == 2'd0) e1_d = tap;
        else             e2_d = tap;
        n_d = n_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= 1'b0; n_q <= '0; e1_q <= '0; e2_q <= '0;
    end else begin
      prev_q <= prev_d; n_q <= n_d; e1_q <= e1_d; e2_q <= e2_d;
    end

  assign n_edges = n_q;
  assign e1 = e1_q;
  assign e2 = e2_q;
endmodule

// File: rtl/cal_recal_timer.sv
module cal_recal_timer #(
  parameter int INTERVAL = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic take,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, pend_q, pend_d;

  always_comb begin
    cnt_d = cnt_q; run_d = run_q; pend_d = pend_q;
    if (take) begin
      run_d = 1'b0; pend_d = 1'b0;
    end else if (arm) begin
      run_d = 1'b1; pend_d = 1'b0; cnt_d = '0;
    end else if (run_q && !pend_q) begin
      if (cnt_q == CW'(INTERVAL - 1)) pend_d = 1'b1;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0; run_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; run_q <= run_d; pend_q <= pend_d;
    end

  assign pend = pend_q;
endmodule

// File: rtl/cal_tap_bank.sv
module cal_tap_bank #(
  parameter int NBITS = 8,
  parameter int TAP_W = 6,
  localparam int BW = $clog2(NBITS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [BW-1:0]          wsel,
  input  logic [TAP_W-1:0]       wtap,
  input  logic                   werr,
  output logic [NBITS*TAP_W-1:0] taps,
  output logic [NBITS-1:0]       errs
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic             we;
    logic [TAP_W-1:0] tap_q;
    logic             err_q;
    assign we = wr && (wsel == BW'(b));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        tap_q <= '0; err_q <= 1'b0;
      end else if (we) begin
        tap_q <= wtap; err_q <= werr;
      end
    assign taps[b*TAP_W +: TAP_W] = tap_q;
    assign errs[b] = err_q;
  end
endmodule

// File: rtl/dq_capture_trainer.sv
module dq_capture_trainer #(
  parameter int NBITS          = 8,
  parameter int TAP_W          = 6,
  parameter int SETTLE         = 4,
  parameter int VOTES          = 8,
  parameter int HALF_EYE       = 16,
  parameter int RECAL_INTERVAL = 100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_start,
  input  logic                   rd_idle,
  input  logic                   dqs_smp,
  input  logic [NBITS-1:0]       dq_smp,
  output logic                   cal_done,
  output logic                   recal_req,
  output logic [NBITS*TAP_W-1:0] tap_val,
  output logic [NBITS-1:0]       tap_load,
  output logic [NBITS-1:0]       cal_err
);
  import cal_pkg::*;
  localparam int BW   = $clog2(NBITS);
  localparam int CMAX = (SETTLE > VOTES) ? SETTLE : VOTES;
  localparam int CNTW = $clog2(CMAX + 1);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  localparam logic [TAP_W:0]   HALF_W  = (TAP_W+1)'(HALF_EYE);

  cal_state_e       st_q, st_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic             rec_q, rec_d;
  logic v_clr, v_en, maj, e_clr, e_en, wr, load, arm, take, pend;
  logic [1:0]       n_edges;
  logic [TAP_W-1:0] e1, e2, prev_tap, tgt, new_tap;
  logic [TAP_W:0]   sum_w, up_w;
  logic [NBITS*TAP_W-1:0] bank_taps;
  logic             drive_en;
  logic [TAP_W-1:0] drive_tap;

  cal_vote_acc #(.VOTES(VOTES)) u_vote (
    .clk(clk), .rst_n(rst_n), .clr(v_clr), .en(v_en),
    .din(dq_smp[bit_q] ^ dqs_smp), .maj(maj));

  cal_edge_find #(.TAP_W(TAP_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .clr(e_clr), .en(e_en), .first(tap_q == '0),
    .val(maj), .tap(tap_q), .n_edges(n_edges), .e1(e1), .e2(e2));

  cal_recal_timer #(.INTERVAL(RECAL_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .take(take), .pend(pend));

  cal_tap_bank #(.NBITS(NBITS), .TAP_W(TAP_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wsel(bit_q), .wtap(new_tap),
    .werr(n_edges == 2'd0), .taps(bank_taps), .errs(cal_err));

  // Target tap from the edges found for the bit under training.
  always_comb begin
    prev_tap = bank_taps[bit_q*TAP_W +: TAP_W];
    sum_w    = {1'b0, e1} + {1'b0, e2};
    up_w     = {1'b0, e1} + HALF_W;
    if (n_edges == 2'd2)              tgt = TAP_W'(sum_w >> 1);
    else if (n_edges == 2'd0)         tgt = prev_tap;
    else if ({1'b0, e1} >= HALF_W)    tgt = TAP_W'({1'b0, e1} - HALF_W);
    else if (up_w > {1'b0, TAP_MAX})  tgt = TAP_MAX;
    else                              tgt = up_w[TAP_W-1:0];
    new_tap = tgt;
    if (rec_q) begin
      if (tgt > prev_tap)      new_tap = prev_tap + 1'b1;
      else if (tgt < prev_tap) new_tap = prev_tap - 1'b1;
      else                     new_tap = prev_tap;
    end
  end

  // Sequencer next state.
  always_comb begin
    st_d = st_q; bit_d = bit_q; tap_d = tap_q; cnt_d = cnt_q; rec_d = rec_q;
    v_clr = 1'b0; v_en = 1'b0; e_clr = 1'b0; e_en = 1'b0;
    wr = 1'b0; load = 1'b0; cal_done = 1'b0; arm = 1'b0; take = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (cal_start || (pend && rd_idle)) begin
          rec_d = !cal_start;
          bit_d = '0; tap_d = '0; e_clr = 1'b1; take = 1'b1;
          st_d  = S_LOAD;
        end
      end
      S_LOAD: begin
        load = 1'b1; v_clr = 1'b1; cnt_d = '0; st_d = S_SETTLE;
      end
      S_SETTLE: begin
        if (cnt_q == CNTW'(SETTLE - 1)) begin
          cnt_d = '0; st_d = S_VOTE;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_VOTE: begin
        v_en = 1'b1;
        if (cnt_q == CNTW'(VOTES - 1)) st_d = S_DECIDE;
        else                           cnt_d = cnt_q + 1'b1;
      end
      S_DECIDE: begin
        e_en = 1'b1;
        if (tap_q == TAP_MAX) st_d = S_APPLY;
        else begin
          tap_d = tap_q + 1'b1; st_d = S_LOAD;
        end
      end
      S_APPLY: begin
        wr = 1'b1; load = 1'b1;
        if (bit_q == BW'(NBITS - 1)) st_d = S_DONE;
        else begin
          bit_d = bit_q + 1'b1; tap_d = '0; e_clr = 1'b1; st_d = S_LOAD;
        end
      end
      S_DONE: begin
        cal_done = 1'b1; arm = 1'b1; st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= S_IDLE; bit_q <= '0; tap_q <= '0; cnt_q <= '0; rec_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; tap_q <= tap_d; cnt_q <= cnt_d; rec_q <= rec_d;
    end

  assign drive_en  = (st_q != S_IDLE) && (st_q != S_DONE);
  assign drive_tap = (st_q == S_APPLY) ? new_tap : tap_q;
  assign recal_req = pend;

  for (genvar b = 0; b < NBITS; b++) begin : g_out
    logic sel;
    assign sel = drive_en && (bit_q == BW'(b));
    assign tap_val[b*TAP_W +: TAP_W] = sel ? drive_tap : bank_taps[b*TAP_W +: TAP_W];
    assign tap_load[b] = load && (bit_q == BW'(b));
  end
endmodule

// File: rtl/dq_capture_trainer_chk.sv
module dq_capture_trainer_chk #(
  parameter int NBITS = 8,
  parameter int TAP_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cal_done,
  input logic                rd_idle,
  input logic [NBITS-1:0]    tap_load,
  input cal_pkg::cal_state_e st,
  input logic                rec,
  input logic [TAP_W-1:0]    old_tap,
  input logic [TAP_W-1:0]    new_tap
);
  import cal_pkg::*;

  // R4: one delay element is loaded at a time
  a_r4_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tap_load));

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  // R8: completion follows the last final-tap load
  a_r8_done_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> $past(st) == S_APPLY);

  // R9: a tracking pass only begins after an idle read path
  a_r9_recal_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && $past(st) == S_IDLE && rec) |-> $past(rd_idle));

  // R10: tracking pass moves a tap by at most one step
  a_r10_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_APPLY && rec) |->
      (new_tap == old_tap) ||
      ({1'b0, new_tap} == {1'b0, old_tap} + 1'b1) ||
      ({1'b0, old_tap} == {1'b0, new_tap} + 1'b1));
endmodule

bind dq_capture_trainer dq_capture_trainer_chk #(.NBITS(NBITS), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .rd_idle(rd_idle),
  .tap_load(tap_load), .st(st_q), .rec(rec_q), .old_tap(prev_tap), .new_tap(new_tap));

// File: tb/tb_dq_capture_trainer.sv
module tb_dq_capture_trainer;
  localparam int NB = 8, TW = 6, SET = 3, HALF = 16, INTV = 3000;

  logic clk = 1'b0, rst_n = 1'b0, cal_start = 1'b0, rd_idle = 1'b1, dqs_smp = 1'b0;
  logic [NB-1:0] dq_smp, tap_load, cal_err;
  logic [NB*TW-1:0] tap_val;
  logic cal_done, recal_req;

  dq_capture_trainer #(.NBITS(NB), .TAP_W(TW), .SETTLE(SET), .VOTES(8),
    .HALF_EYE(HALF), .RECAL_INTERVAL(INTV)) dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .rd_idle(rd_idle),
    .dqs_smp(dqs_smp), .dq_smp(dq_smp), .cal_done(cal_done), .recal_req(recal_req),
    .tap_val(tap_val), .tap_load(tap_load), .cal_err(cal_err));

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, failures = 0;
  int lo[NB], hi[NB], prev[NB], cur_tap[NB], stl[NB];
  int cyc = 0, load_cnt = 0;
  logic noise_en = 1'b0, hold_chk = 1'b0, done_seen = 1'b0;
  logic [NB*TW-1:0] exp_tap_q[$];
  logic [NB-1:0]    exp_err_q[$];
  string            exp_tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit inwin(int b, int t);
    return (t >= lo[b]) && (t < hi[b]);
  endfunction

  // Behavioural delay element: data is inverted for SET cycles after a load (R3).
  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int b = 0; b < NB; b++) begin
      if (tap_load[b]) begin
        cur_tap[b] <= int'(tap_val[b*TW +: TW]);
        stl[b] <= SET;
      end else if (stl[b] > 0) stl[b] <= stl[b] - 1;
    end
  end

  always_comb
    for (int b = 0; b < NB; b++)
      dq_smp[b] = ((cur_tap[b] >= lo[b]) && (cur_tap[b] < hi[b])) ^ (stl[b] > 0)
                  ^ (noise_en && ((cyc + b) % 7 == 0)) ^ dqs_smp;

  // Driver: expected taps from the requirements (R5, R6, R7, R10).
  task automatic push_pass(input bit rec, input string tag);
    logic [NB*TW-1:0] et;
    logic [NB-1:0] ee;
    for (int b = 0; b < NB; b++) begin
      int n = 0, e1 = 0, e2 = 0, tg;
      for (int t = 1; t < 64; t++)
        if (inwin(b, t) != inwin(b, t - 1)) begin
          if (n == 0) e1 = t; else if (n == 1) e2 = t;
          n++;
        end
      if (n >= 2)       tg = (e1 + e2) / 2;
      else if (n == 1)  tg = (e1 >= HALF) ? e1 - HALF : ((e1 + HALF > 63) ? 63 : e1 + HALF);
      else              tg = prev[b];
      if (rec && n > 0) tg = (tg > prev[b]) ? prev[b] + 1 : (tg < prev[b]) ? prev[b] - 1 : prev[b];
      ee[b] = (n == 0);
      prev[b] = tg;
      et[b*TW +: TW] = TW'(tg);
    end
    exp_tap_q.push_back(et); exp_err_q.push_back(ee); exp_tag_q.push_back(tag);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) if (rst_n) begin
    if (done_seen) check(cal_done == 1'b0, "R8", "done width", cal_done, 0);
    done_seen = cal_done;
    if (hold_chk && |tap_load) check(1'b0, "R9", "load while busy", tap_load, 0);
    if (|tap_load) load_cnt++;
    if (cal_done) begin
      logic [NB*TW-1:0] et;
      logic [NB-1:0] ee;
      string tg;
      if (exp_tap_q.size() == 0) check(1'b0, "R8", "unexpected done", 1, 0);
      else begin
        et = exp_tap_q.pop_front(); ee = exp_err_q.pop_front(); tg = exp_tag_q.pop_front();
        for (int b = 0; b < NB; b++)
          check(tap_val[b*TW +: TW] == et[b*TW +: TW], tg, $sformatf("bit%0d tap", b),
                tap_val[b*TW +: TW], et[b*TW +: TW]);
        check(cal_err == ee, "R7", "error flags", cal_err, ee);
        check(load_cnt == NB * 65, "R4", "load count", load_cnt, NB * 65);
      end
      load_cnt = 0;
    end
  end

  task automatic run_pass(input bit use_start);
    if (use_start) begin
      cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    end
    while (!cal_done) @(negedge clk);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin prev[b] = 0; cur_tap[b] = 0; stl[b] = 0; lo[b] = 0; hi[b] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tap_val == '0, "R1", "tap_val", tap_val, 0);
    check(tap_load == '0 && cal_err == '0, "R1", "load/err", {tap_load, cal_err}, 0);
    check(!cal_done && !recal_req, "R1", "done/req", {cal_done, recal_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Pass 1: two edges, one edge both sides, no edge (R5 R6 R7)
    lo = '{10, 3, 20, 0, 40, 0, 0, 33}; hi = '{30, 50, 21, 20, 64, 10, 64, 62};
    push_pass(1'b0, "R5 R6");
    run_pass(1'b1);
    @(negedge clk);

    // Pass 2: strobe high with inverted data and read noise (R2 R3)
    dqs_smp = 1'b1; noise_en = 1'b1;
    lo = '{5, 12, 30, 8, 2, 50, 16, 20}; hi = '{25, 40, 63, 9, 60, 64, 48, 20};
    push_pass(1'b0, "R2 R3");
    run_pass(1'b1);
    rd_idle = 1'b0;
    noise_en = 1'b0; dqs_smp = 1'b0;

    // R9: timer expiry, then wait for idle
    repeat (INTV - 5) @(negedge clk);
    check(recal_req == 1'b0, "R9", "req early", recal_req, 0);
    repeat (10) @(negedge clk);
    check(recal_req == 1'b1, "R9", "req due", recal_req, 1);
    hold_chk = 1'b1;
    repeat (50) @(negedge clk);
    check(recal_req == 1'b1, "R9", "req held", recal_req, 1);
    hold_chk = 1'b0;

    // Pass 3: tracking pass with moved eyes (R10)
    lo = '{10, 8, 30, 0, 2, 50, 0, 21}; hi = '{25, 40, 63, 64, 60, 64, 48, 22};
    push_pass(1'b1, "R10");
    rd_idle = 1'b1;
    run_pass(1'b0);
    @(negedge clk);
    check(recal_req == 1'b0, "R9", "req cleared", recal_req, 0);

    // Pass 4: full pass moves taps freely (R10 contrast)
    lo = '{10, 3, 20, 0, 40, 0, 0, 33}; hi = '{30, 50, 21, 20, 64, 10, 64, 62};
    push_pass(1'b0, "R10 full");
    run_pass(1'b1);
    repeat (3) @(negedge clk);
    check(exp_tap_q.size() == 0, "R8", "passes pending", exp_tap_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule